// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host three byte-wide general-purpose ports. They are called A, B and C. Port C is split into a high nibble and a low nibble, and each nibble has its own direction. The host reaches the block through a select, a read strobe, a write strobe, a 2-bit register index and separate write and read data buses. One configuration register holds the direction of port A, port B, the high half of C and the low half of C. Each port has an output latch. Each port, or half of port C, has an output-enable, so the pads can be tristated outside the block.

A configuration write changes the directions only when its top bit is set. The mode fields in that word are accepted but have no effect: every port works as plain input/output. A read of a port returns the pad value for each input part and the latch value for each output part. Port C is always read and written as one byte, even though its two nibbles can differ in direction.

Top module: `ppio_ctrl`

## Requirements
- R1: The register index selects port A at 0, port B at 1, port C at 2 and the configuration register at 3.
- R2: While reset is active and after it, every output-enable is 0, every output latch is 0, and the configuration reads back as 9Bh.
- R3: A configuration write with bit 7 set loads the directions on the next clock edge: bit 4 sets port A, bit 3 sets the high half of C, bit 1 sets port B and bit 0 sets the low half of C. A value of 1 means input, so the matching output-enable is low. For example, 98h gives A input, B output, high C input and low C output.
- R4: A configuration write with bit 7 clear leaves the directions and the read-back value unchanged.
- R5: The mode fields (bits 6:5 and bit 2) of a configuration write are ignored and read back as 0. Only the four direction bits take effect.
- R6: A port read returns the pad value for each input part and the latch value for each output part. For port C this choice is made per nibble.
- R7: A port write loads that port's latch whether the port is an input or an output. The latch value always appears on the port's output pins.
- R8: A write to port C loads all 8 latch bits at once, whatever the direction of each nibble.
- R9: A read of index 3 returns bit 7 = 1, bits 6:5 = 0, bit 4 = A direction, bit 3 = high C direction, bit 2 = 0, bit 1 = B direction and bit 0 = low C direction.
- R10: The read data is 0 in any cycle where select and read are not both high.
- R11: A write strobe with select low changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Block select, active high |
| host_rd | input | 1 | Read strobe, active high; data returned in the same cycle |
| host_wr | input | 1 | Write strobe, active high; captured at the clock edge |
| host_addr | input | 2 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C output latch |
| pc_oe_hi | output | 1 | Output enable for port C bits 7:4 |
| pc_oe_lo | output | 1 | Output enable for port C bits 3:0 |

## Verification
The bench steps through several configuration words. These are the reset state, 98h, 82h, FFh, E4h and 81h, and each one puts a different mix of input and output on the two whole ports and the two halves of C. Reads of port C under split directions show whether the nibble choice is made per half rather than per port. Latches written while a port was an input, and read back after the port turns to output, show that storage is separate from direction. Writes with the flag bit clear, writes with select low, and words with nonzero mode fields are each followed by a configuration read-back and a check of the enables. This separates ignored writes from accepted ones.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PA  = 2'd0,
    SEL_PB  = 2'd1,
    SEL_PC  = 2'd2,
    SEL_CFG = 2'd3
  } reg_sel_e;

  // configuration word bit positions
  localparam int unsigned CW_SET = 7;
  localparam int unsigned CW_A   = 4;
  localparam int unsigned CW_CU  = 3;
  localparam int unsigned CW_B   = 1;
  localparam int unsigned CW_CL  = 0;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_cfg_t;

  localparam dir_cfg_t DIR_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppio_rst_sync.sv
module ppio_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
  import ppio_pkg::*;
#(
  parameter int unsigned DW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output dir_cfg_t      dir
);
  dir_cfg_t dir_q, dir_d;
  logic     load;

  // only a word with the set flag reconfigures; mode fields are dropped
  assign load = wr_en & wdata[CW_SET];

  always_comb begin
    dir_d = dir_q;
    if (load) begin
      dir_d.a_in  = wdata[CW_A];
      dir_d.cu_in = wdata[CW_CU];
      dir_d.b_in  = wdata[CW_B];
      dir_d.cl_in = wdata[CW_CL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= DIR_RESET;
    else if (load) dir_q <= dir_d;
  end

  assign dir = dir_q;
endmodule

// File: rtl/ppio_out_latch.sv
module ppio_out_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (wr_en) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (wr_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/ppio_rd_mux.sv
module ppio_rd_mux
  import ppio_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  dir_cfg_t          dir,
  input  logic [W-1:0]      pa_pin,
  input  logic [W-1:0]      pb_pin,
  input  logic [W-1:0]      pc_pin,
  input  logic [W-1:0]      pa_lat,
  input  logic [W-1:0]      pb_lat,
  input  logic [W-1:0]      pc_lat,
  output logic [W-1:0]      rdata
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] pc_view;
  logic [W-1:0] cfg_view;

  assign pc_view[W-1:H] = dir.cu_in ? pc_pin[W-1:H] : pc_lat[W-1:H];
  assign pc_view[H-1:0] = dir.cl_in ? pc_pin[H-1:0] : pc_lat[H-1:0];

  always_comb begin
    cfg_view         = '0;
    cfg_view[CW_SET] = 1'b1;
    cfg_view[CW_A]   = dir.a_in;
    cfg_view[CW_CU]  = dir.cu_in;
    cfg_view[CW_B]   = dir.b_in;
    cfg_view[CW_CL]  = dir.cl_in;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        SEL_PA:  rdata = dir.a_in ? pa_pin : pa_lat;
        SEL_PB:  rdata = dir.b_in ? pb_pin : pb_lat;
        SEL_PC:  rdata = pc_view;
        default: rdata = cfg_view;
      endcase
    end
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  output logic [W-1:0]      host_rdata,
  input  logic [W-1:0]      pa_in,
  output logic [W-1:0]      pa_out,
  output logic              pa_oe,
  input  logic [W-1:0]      pb_in,
  output logic [W-1:0]      pb_out,
  output logic              pb_oe,
  input  logic [W-1:0]      pc_in,
  output logic [W-1:0]      pc_out,
  output logic              pc_oe_hi,
  output logic              pc_oe_lo
);
  localparam int unsigned NUM_PORTS = 3;

  logic         rst_n_s;
  logic         wr_cyc;
  logic         rd_cyc;
  logic [3:0]   wr_hit;
  dir_cfg_t     dir;
  logic [W-1:0] lat_q [NUM_PORTS];

  ppio_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  assign wr_cyc = host_sel & host_wr;
  assign rd_cyc = host_sel & host_rd;

  always_comb begin
    wr_hit = '0;
    if (wr_cyc) wr_hit[host_addr] = 1'b1;
  end

  ppio_cfg_reg #(.DW(W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (wr_hit[SEL_CFG]),
    .wdata (host_wdata),
    .dir   (dir)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lat
    ppio_out_latch #(.W(W)) u_lat (
      .clk   (clk),
      .rst_n (rst_n_s),
      .wr_en (wr_hit[p]),
      .wdata (host_wdata),
      .q     (lat_q[p])
    );
  end

  ppio_rd_mux #(.W(W)) u_rd (
    .rd_en  (rd_cyc),
    .addr   (host_addr),
    .dir    (dir),
    .pa_pin (pa_in),
    .pb_pin (pb_in),
    .pc_pin (pc_in),
    .pa_lat (lat_q[SEL_PA]),
    .pb_lat (lat_q[SEL_PB]),
    .pc_lat (lat_q[SEL_PC]),
    .rdata  (host_rdata)
  );

  assign pa_out   = lat_q[SEL_PA];
  assign pb_out   = lat_q[SEL_PB];
  assign pc_out   = lat_q[SEL_PC];
  assign pa_oe    = ~dir.a_in;
  assign pb_oe    = ~dir.b_in;
  assign pc_oe_hi = ~dir.cu_in;
  assign pc_oe_lo = ~dir.cl_in;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_sel,
  input logic         host_rd,
  input logic         host_wr,
  input logic [1:0]   host_addr,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] host_rdata,
  input logic [W-1:0] pa_in,
  input logic [W-1:0] pa_out,
  input logic         pa_oe,
  input logic [W-1:0] pb_out,
  input logic         pb_oe,
  input logic [W-1:0] pc_out,
  input logic         pc_oe_hi,
  input logic         pc_oe_lo
);
  logic cfg_wr, pa_wr, rd_cyc;
  assign cfg_wr = host_sel && host_wr && host_addr == 2'd3;
  assign pa_wr  = host_sel && host_wr && host_addr == 2'd0;
  assign rd_cyc = host_sel && host_rd;

  a_r2_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!pa_oe && !pb_oe && !pc_oe_hi && !pc_oe_lo &&
                pa_out == '0 && pb_out == '0 && pc_out == '0));

  a_r3_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && host_wdata[7]) |=>
      (pa_oe == !$past(host_wdata[4]) && pc_oe_hi == !$past(host_wdata[3]) &&
       pb_oe == !$past(host_wdata[1]) && pc_oe_lo == !$past(host_wdata[0])));

  a_r4_flag_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !host_wdata[7]) |=> $stable({pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}));

  a_r6_input_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && host_addr == 2'd0 && !pa_oe) |-> host_rdata == pa_in);

  a_r7_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    pa_wr |=> pa_out == $past(host_wdata));

  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_wr |=> $stable(pa_out));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |-> host_rdata == '0);
endmodule

bind ppio_ctrl ppio_ctrl_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .pa_in      (pa_in),
  .pa_out     (pa_out),
  .pa_oe      (pa_oe),
  .pb_out     (pb_out),
  .pb_oe      (pb_oe),
  .pc_out     (pc_out),
  .pc_oe_hi   (pc_oe_hi),
  .pc_oe_lo   (pc_oe_lo)
);

// File: tb/test_ppio_ctrl.sv
module test_ppio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'h11, pc_in = 8'h7E;
  logic [7:0] pa_out, pb_out, pc_out;
  logic       pa_oe, pb_oe, pc_oe_hi, pc_oe_lo;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  ppio_ctrl i_ppio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_sel(sel), .host_rd(rd), .host_wr(wr), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe_hi(pc_oe_hi), .pc_oe_lo(pc_oe_lo)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: write cycle, captured at the next rising edge
  task automatic bus_wr(input logic s, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sel = s; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  // driver: read cycle, expected value queued for the monitor
  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    sel = 1'b1; rd = 1'b1; addr = a;
    @(posedge clk); #1;
    sel = 1'b0; rd = 1'b0;
  endtask

  // pin check: oe order {a, b, c_hi, c_lo}
  task automatic pins(input string tag, input logic [3:0] oe,
                      input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    chk8({tag, " oe"}, {4'h0, pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, {4'h0, oe});
    chk8({tag, " pa_out"}, pa_out, a);
    chk8({tag, " pb_out"}, pb_out, b);
    chk8({tag, " pc_out"}, pc_out, c);
  endtask

  // monitor: scoreboard comparison away from the active edge
  always @(negedge clk) begin
    if (sel && rd) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1 unexpected read actual=%02h expected=none", rdata);
      end else begin
        chk8(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    pins("R2 in reset", 4'b0000, 8'h00, 8'h00, 8'h00);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    pins("R2 after reset", 4'b0000, 8'h00, 8'h00, 8'h00);
    bus_rd(2'd3, 8'h9B, "R2 R9 reset config");
    bus_rd(2'd0, 8'h5A, "R1 R6 port A pins");
    bus_rd(2'd1, 8'h11, "R1 R6 port B pins");
    bus_rd(2'd2, 8'h7E, "R1 R6 port C pins");
    @(negedge clk); chk8("R10 idle read data", rdata, 8'h00);

    bus_wr(1'b1, 2'd0, 8'hC3);
    pins("R7 latch while input", 4'b0000, 8'hC3, 8'h00, 8'h00);
    bus_rd(2'd0, 8'h5A, "R6 input ignores latch");

    bus_wr(1'b1, 2'd3, 8'h98);
    pins("R3 word 98", 4'b0101, 8'hC3, 8'h00, 8'h00);
    bus_rd(2'd3, 8'h98, "R9 readback 98");
    bus_wr(1'b1, 2'd1, 8'h3C);
    bus_rd(2'd1, 8'h3C, "R6 port B output latch");
    bus_wr(1'b1, 2'd2, 8'hA5);
    bus_rd(2'd2, 8'h75, "R6 port C split high in low out");
    pins("R8 port C whole byte", 4'b0101, 8'hC3, 8'h3C, 8'hA5);

    bus_wr(1'b1, 2'd3, 8'h18);
    pins("R4 flag clear", 4'b0101, 8'hC3, 8'h3C, 8'hA5);
    bus_rd(2'd3, 8'h98, "R4 readback unchanged");

    bus_wr(1'b1, 2'd3, 8'h82);
    pins("R3 word 82", 4'b1011, 8'hC3, 8'h3C, 8'hA5);
    bus_rd(2'd0, 8'hC3, "R7 latch kept from input time");
    bus_rd(2'd1, 8'h11, "R6 port B now input");
    bus_rd(2'd2, 8'hA5, "R8 port C full latch");

    bus_wr(1'b0, 2'd0, 8'h00);
    bus_wr(1'b0, 2'd3, 8'h9B);
    pins("R11 select low", 4'b1011, 8'hC3, 8'h3C, 8'hA5);

    bus_wr(1'b1, 2'd3, 8'hFF);
    pins("R5 word FF", 4'b0000, 8'hC3, 8'h3C, 8'hA5);
    bus_rd(2'd3, 8'h9B, "R5 mode bits read zero");
    bus_wr(1'b1, 2'd3, 8'hE4);
    pins("R5 word E4", 4'b1111, 8'hC3, 8'h3C, 8'hA5);
    bus_rd(2'd3, 8'h80, "R5 R9 readback E4");

    bus_wr(1'b1, 2'd3, 8'h81);
    pins("R3 word 81", 4'b1110, 8'hC3, 8'h3C, 8'hA5);
    bus_rd(2'd2, 8'hAE, "R6 port C split high out low in");
    bus_rd(2'd3, 8'h81, "R9 readback 81");
    bus_wr(1'b1, 2'd2, 8'h0F);
    bus_rd(2'd2, 8'h0E, "R8 R6 port C rewrite");
    pa_in = 8'h96;
    bus_rd(2'd0, 8'hC3, "R6 output ignores pins");

    repeat (2) @(posedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 reads left actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule